// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block turns transitions on a set of interrupt lines into sticky pending requests and one-cycle event pulses. The lower group of lines is fed from general-purpose I/O pins. Each of these lines picks the pin with the same index from one of several ports, under a small per-line port field. The upper group of lines is wired straight to peripheral event outputs.

For every line, software chooses which edges count: rising, falling or both. It also chooses whether a detected edge raises a pending interrupt, a one-cycle event pulse, or both. Each line has an asynchronous capture flop for each edge polarity, so a pulse shorter than one clock period is still caught. A two-flop synchronizer then brings the capture into the clock domain.

Pending bits stay set until software writes a 1 to them. A software-set register raises requests without any activity on the line. Priority between lines is not handled here; it is left to the interrupt controller downstream.

Top module: `edge_irq_ctrl`

## Requirements
- R1: There are 28 lines. Line n (n = 0..15) follows `gpio_i[p*16 + n]`, where p is the 2-bit field at bits [2n+1:2n] of the port-select register (address 4). Line n (n = 16..27) follows `periph_i[n-16]`.
- R2: A rising edge on line n counts only when bit n of the rise-enable register (address 0) is 1. A falling edge counts only when bit n of the fall-enable register (address 1) is 1. With both bits set, both edges count.
- R3: A pulse whose two edges both fall between two consecutive clock edges is detected once, provided either of its edges is enabled.
- R4: A counted trigger sets pending bit n only if bit n of the interrupt-enable register (address 2) is 1. Triggers on a line whose interrupt enable is 0 are dropped. `irq_o[n]` is high exactly when pending bit n and interrupt-enable bit n are both 1.
- R5: A pending bit stays set until a write to address 6 has a 1 at its position. Writing 0 leaves it unchanged. A trigger that lands on the same clock edge as the clearing write leaves the bit set.
- R6: Writing the software-set register (address 5) counts as a trigger on every line whose data bit is 1, with the same enable rules as an edge. Address 5 reads as 0.
- R7: `evt_o[n]` is high for exactly one cycle, on the same cycle a trigger on line n would set the pending bit. It is gated only by bit n of the event-enable register (address 3), not by the interrupt enable.
- R8: An edge that occurs between clock edges k and k+1 shows on pending, `irq_o` and `evt_o` right after clock edge k+3. A write sampled at clock edge e takes effect right after edge e.
- R9: While `rst_ni` is low, every register and every output is 0.
- R10: Activity on a GPIO pin of a port that is not selected for that pin's line has no effect.
- R11: Addresses 0 to 4 read back the last value written, with unused upper bits 0. Address 6 reads the pending bits. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gpio_i | input | 64 | GPIO pins, port p pin n at index p*16+n |
| periph_i | input | 12 | Internal peripheral event lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address, for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 28 | Interrupt request per line |
| evt_o | output | 28 | One-cycle event pulse per line |

## Verification
The assertions check three things on every cycle. First, a pending bit never rises without a trigger that is enabled for interrupts on the previous edge. Second, a pending bit never drops without a clearing write. Third, a trigger always wins over a clear on the same edge, and a capture stage never produces two consecutive pulses. Some behaviours can only be shown by the bench's scenarios: the three-edge latency, sub-period pulses being caught once, port selection ignoring other ports, and the separation between interrupt and event masks. For these, the bench drives edges between clock edges and compares against its scheduled model on every cycle.

// File: rtl/irqline_pkg.sv
package irqline_pkg;

    // register selector; the address value is the decode key
    typedef enum logic [2:0] {
        RS_RISE  = 3'd0,
        RS_FALL  = 3'd1,
        RS_IRQEN = 3'd2,
        RS_EVTEN = 3'd3,
        RS_PSEL  = 3'd4,
        RS_SWSET = 3'd5,
        RS_PEND  = 3'd6,
        RS_SPARE = 3'd7
    } reg_sel_e;

    localparam int unsigned DEF_PINS  = 16;
    localparam int unsigned DEF_PORTS = 4;
    localparam int unsigned DEF_PERIPH = 12;
    localparam int unsigned DEF_DW    = 32;
    localparam int unsigned DEF_SYNC  = 2;

endpackage

// File: rtl/pin_port_mux.sv
module pin_port_mux #(
    parameter int unsigned PINS  = 16,
    parameter int unsigned PORTS = 4,
    localparam int unsigned SELW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [PORTS*PINS-1:0] gpio_i,
    input  logic [PINS*SELW-1:0]  psel_i,
    output logic [PINS-1:0]       line_o
);

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        logic [SELW-1:0] sel;
        assign sel = psel_i[n*SELW +: SELW];
        always_comb begin
            line_o[n] = 1'b0;
            for (int p = 0; p < PORTS; p++) begin
                if (sel == SELW'(p)) begin
                    line_o[n] = gpio_i[p*PINS + n];
                end
            end
        end
    end

endmodule

// File: rtl/edge_catch.sv
module edge_catch #(
    parameter bit          FALLING = 1'b0,
    parameter int unsigned STAGES  = irqline_pkg::DEF_SYNC
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic pulse_o
);

    logic              caught;
    logic              clr_async;
    logic [STAGES:0]   sync_d;
    logic [STAGES:0]   sync_q;

    // capture flop is released only once the synchronized copy has dropped
    assign clr_async = ~rst_ni | sync_q[STAGES-1];

    if (FALLING) begin : g_fall
        always_ff @(negedge sig_i or posedge clr_async) begin
            if (clr_async) caught <= 1'b0;
            else           caught <= 1'b1;
        end
    end else begin : g_rise
        always_ff @(posedge sig_i or posedge clr_async) begin
            if (clr_async) caught <= 1'b0;
            else           caught <= 1'b1;
        end
    end

    always_comb begin
        sync_d = {sync_q[STAGES-1:0], caught};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign pulse_o = sync_q[STAGES-1] & ~sync_q[STAGES];

    // R3
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import irqline_pkg::*;
#(
    parameter int unsigned PINS   = DEF_PINS,
    parameter int unsigned PORTS  = DEF_PORTS,
    parameter int unsigned PERIPH = DEF_PERIPH,
    parameter int unsigned DW     = DEF_DW,      // must cover NL and SELBITS
    parameter int unsigned SYNC   = DEF_SYNC,
    localparam int unsigned NL      = PINS + PERIPH,
    localparam int unsigned SELW    = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int unsigned SELBITS = PINS * SELW
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PORTS*PINS-1:0] gpio_i,
    input  logic [PERIPH-1:0]     periph_i,
    input  logic                  wr_en_i,
    input  logic [2:0]            addr_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    output logic [NL-1:0]         irq_o,
    output logic [NL-1:0]         evt_o
);

    typedef struct packed {
        logic [NL-1:0]      rise_en;
        logic [NL-1:0]      fall_en;
        logic [NL-1:0]      irq_en;
        logic [NL-1:0]      evt_en;
        logic [NL-1:0]      pend;
        logic [NL-1:0]      evt;
        logic [SELBITS-1:0] psel;
    } state_t;

    state_t state_d, state_q;

    logic [PINS-1:0] pin_line;
    logic [NL-1:0]   line;
    logic [NL-1:0]   rise_hit;
    logic [NL-1:0]   fall_hit;
    logic [NL-1:0]   sw_vec;
    logic [NL-1:0]   clr_vec;
    logic [NL-1:0]   trig;
    reg_sel_e        sel;

    assign sel = reg_sel_e'(addr_i);

    pin_port_mux #(.PINS(PINS), .PORTS(PORTS)) u_mux (
        .gpio_i (gpio_i),
        .psel_i (state_q.psel),
        .line_o (pin_line)
    );

    assign line = {periph_i, pin_line};

    for (genvar n = 0; n < NL; n++) begin : g_line
        edge_catch #(.FALLING(1'b0), .STAGES(SYNC)) u_rise (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sig_i   (line[n]),
            .pulse_o (rise_hit[n])
        );
        edge_catch #(.FALLING(1'b1), .STAGES(SYNC)) u_fall (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .sig_i   (line[n]),
            .pulse_o (fall_hit[n])
        );
    end

    always_comb begin
        sw_vec  = (wr_en_i && sel == RS_SWSET) ? wdata_i[NL-1:0] : '0;
        clr_vec = (wr_en_i && sel == RS_PEND)  ? wdata_i[NL-1:0] : '0;
        trig    = (rise_hit & state_q.rise_en) | (fall_hit & state_q.fall_en) | sw_vec;

        state_d      = state_q;
        state_d.pend = (state_q.pend & ~clr_vec) | (trig & state_q.irq_en);
        state_d.evt  = trig & state_q.evt_en;
        if (wr_en_i) begin
            unique case (sel)
                RS_RISE:  state_d.rise_en = wdata_i[NL-1:0];
                RS_FALL:  state_d.fall_en = wdata_i[NL-1:0];
                RS_IRQEN: state_d.irq_en  = wdata_i[NL-1:0];
                RS_EVTEN: state_d.evt_en  = wdata_i[NL-1:0];
                RS_PSEL:  state_d.psel    = wdata_i[SELBITS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            RS_RISE:  rdata_o[NL-1:0]      = state_q.rise_en;
            RS_FALL:  rdata_o[NL-1:0]      = state_q.fall_en;
            RS_IRQEN: rdata_o[NL-1:0]      = state_q.irq_en;
            RS_EVTEN: rdata_o[NL-1:0]      = state_q.evt_en;
            RS_PSEL:  rdata_o[SELBITS-1:0] = state_q.psel;
            RS_PEND:  rdata_o[NL-1:0]      = state_q.pend;
            default: ;
        endcase
    end

    assign irq_o = state_q.pend & state_q.irq_en;
    assign evt_o = state_q.evt;

    // R4
    pend_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.pend & ~$past(state_q.pend) & ~$past(trig & state_q.irq_en)) == '0);

    // R5
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_q.pend) & ~state_q.pend & ~$past(clr_vec)) == '0);

    // R5
    edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(trig & state_q.irq_en) & ~state_q.pend) == '0);

endmodule

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] gpio = '0;
    logic [11:0] periph = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [27:0] irq, evt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    logic [27:0] m_rise = '0, m_fall = '0, m_irqen = '0, m_evten = '0, m_pend = '0, m_evt = '0;
    logic [31:0] m_psel = '0;
    logic [27:0] sr [int];
    logic [27:0] sf [int];

    always #2 clk = ~clk;

    edge_irq_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .periph_i(periph),
        .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .evt_o(evt)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return {4'h0, m_rise};
            1: return {4'h0, m_fall};
            2: return {4'h0, m_irqen};
            3: return {4'h0, m_evten};
            4: return m_psel;
            6: return {4'h0, m_pend};
            default: return 32'h0;
        endcase
    endfunction

    // model advances on each clock edge
    always @(posedge clk) begin
        logic [27:0] hr, hf, sw, clr, tr;
        cyc++;
        if (!rst_n) begin
            m_rise = '0; m_fall = '0; m_irqen = '0; m_evten = '0;
            m_pend = '0; m_evt = '0; m_psel = '0;
        end else begin
            hr = sr.exists(cyc) ? sr[cyc] : 28'h0;
            hf = sf.exists(cyc) ? sf[cyc] : 28'h0;
            sw  = (wr && addr == 3'd5) ? wdata[27:0] : 28'h0;
            clr = (wr && addr == 3'd6) ? wdata[27:0] : 28'h0;
            tr = (hr & m_rise) | (hf & m_fall) | sw;
            m_pend = (m_pend & ~clr) | (tr & m_irqen);
            m_evt  = tr & m_evten;
            if (wr) begin
                case (addr)
                    3'd0: m_rise  = wdata[27:0];
                    3'd1: m_fall  = wdata[27:0];
                    3'd2: m_irqen = wdata[27:0];
                    3'd3: m_evten = wdata[27:0];
                    3'd4: m_psel  = wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            chk("R4 R8 irq_o", {4'h0, irq}, {4'h0, m_pend & m_irqen});
            chk("R7 R8 evt_o", {4'h0, evt}, {4'h0, m_evt});
        end
    end

    task automatic sched(input int line, input bit r, input bit f);
        int due;
        logic [27:0] b;
        due = cyc + 3;
        b = 28'(1) << line;
        if (r) sr[due] = (sr.exists(due) ? sr[due] : 28'h0) | b;
        if (f) sf[due] = (sf.exists(due) ? sf[due] : 28'h0) | b;
    endtask

    task automatic setpin(input int port, input int idx, input logic v);
        if (port < 0) periph[idx] = v;
        else          gpio[port*16 + idx] = v;
    endtask

    // kind 0: rising step, 1: falling step, 2: pulse shorter than a clock period
    task automatic drive_edge(input int port, input int idx, input int kind);
        int line;
        bit sel;
        line = (port < 0) ? 16 + idx : idx;
        sel  = (port < 0) || (m_psel[2*idx +: 2] == 2'(port));
        @(negedge clk);
        #0.5;
        case (kind)
            0: begin setpin(port, idx, 1'b1); if (sel) sched(line, 1'b1, 1'b0); end
            1: begin setpin(port, idx, 1'b0); if (sel) sched(line, 1'b0, 1'b1); end
            default: begin
                setpin(port, idx, 1'b1);
                #0.5;
                setpin(port, idx, 1'b0);
                if (sel) sched(line, 1'b1, 1'b1);
            end
        endcase
        repeat (6) @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        @(negedge clk);
        addr = 3'(a);
        #0.5;
        chk(tag, rdata, exp);
        chk({tag, " model"}, rdata, m_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (4) @(negedge clk);
        chk("R9 irq_o in reset", {4'h0, irq}, 32'h0);
        chk("R9 evt_o in reset", {4'h0, evt}, 32'h0);
        addr = 3'd6; #0.5;
        chk("R9 pending in reset", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R11: readback and unused bits
        wr_reg(0, 32'hFFFF_FFFF);
        rd_chk("R11 rise readback", 0, 32'h0FFF_FFFF);
        wr_reg(4, 32'hA5A5_0000);
        rd_chk("R11 psel readback", 4, 32'hA5A5_0000);
        wr_reg(4, 32'h0);
        rd_chk("R11 spare reads 0", 7, 32'h0);

        // baseline: rising only, everything enabled
        wr_reg(1, 32'h0);
        wr_reg(2, 32'h0FFF_FFFF);
        wr_reg(3, 32'h0FFF_FFFF);

        // R2 R8: rising step counts, falling step does not
        drive_edge(0, 3, 0);
        rd_chk("R2 rise sets line 3", 6, 32'h0000_0008);
        drive_edge(0, 3, 1);
        rd_chk("R2 fall ignored when disabled", 6, 32'h0000_0008);

        // R5: write 0 keeps, write 1 clears
        wr_reg(6, 32'h0);
        rd_chk("R5 zero write keeps pending", 6, 32'h0000_0008);
        wr_reg(6, 32'h0000_0008);
        rd_chk("R5 one write clears", 6, 32'h0);

        // R2: falling only on line 5
        wr_reg(0, 32'h0FFF_FFDF);
        wr_reg(1, 32'h0000_0020);
        drive_edge(0, 5, 0);
        rd_chk("R2 rise ignored on fall-only line", 6, 32'h0);
        drive_edge(0, 5, 1);
        rd_chk("R2 fall sets line 5", 6, 32'h0000_0020);
        wr_reg(6, 32'h0FFF_FFFF);

        // R3: pulses shorter than the clock, GPIO and peripheral lines
        drive_edge(0, 7, 2);
        rd_chk("R3 narrow pulse line 7", 6, 32'h0000_0080);
        drive_edge(-1, 4, 2);
        rd_chk("R1 R3 narrow pulse peripheral line 20", 6, 32'h0010_0080);
        wr_reg(6, 32'h0FFF_FFFF);

        // R1 R10: port selection on line 2
        wr_reg(4, 32'h0000_0030);
        drive_edge(1, 2, 2);
        drive_edge(0, 2, 2);
        rd_chk("R10 unselected ports ignored", 6, 32'h0);
        drive_edge(3, 2, 2);
        rd_chk("R1 selected port 3 drives line 2", 6, 32'h0000_0004);
        wr_reg(6, 32'h0FFF_FFFF);

        // R4 R7: interrupt mask vs event mask
        wr_reg(2, 32'h0FFF_FDFF);
        drive_edge(0, 9, 2);
        rd_chk("R4 masked line 9 not pending", 6, 32'h0);
        wr_reg(3, 32'h0FFF_FBFF);
        drive_edge(0, 10, 2);
        rd_chk("R7 event-masked line 10 still pending", 6, 32'h0000_0400);
        wr_reg(6, 32'h0FFF_FFFF);

        // R6: software set, masked line dropped, reads 0
        wr_reg(5, 32'h0000_0203);
        rd_chk("R6 software set", 6, 32'h0000_0003);
        rd_chk("R6 set register reads 0", 5, 32'h0);
        wr_reg(6, 32'h0FFF_FFFF);

        // R5: edge and clear on the same clock edge, edge wins
        @(negedge clk);
        #0.5;
        gpio[11] = 1'b1;
        #0.5;
        gpio[11] = 1'b0;
        sched(11, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        wr = 1'b1; addr = 3'd6; wdata = 32'h0000_0800;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        rd_chk("R5 same-edge trigger beats clear", 6, 32'h0000_0800);
        wr_reg(6, 32'h0000_0800);
        rd_chk("R5 later clear removes", 6, 32'h0);

        // R2: both edges on line 12
        wr_reg(1, 32'h0000_1020);
        drive_edge(0, 12, 0);
        rd_chk("R2 both mode rise", 6, 32'h0000_1000);
        wr_reg(6, 32'h0000_1000);
        drive_edge(0, 12, 1);
        rd_chk("R2 both mode fall", 6, 32'h0000_1000);
        wr_reg(6, 32'h0FFF_FFFF);
        rd_chk("R5 all cleared", 6, 32'h0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule